// File: doc/BRIEF.md
# Coprocessor Context-Save Sequencer

This block runs the main-processor side of a coprocessor context-save instruction. When `start` arrives it checks the decoded opcode. The addressing-mode field sits in the low six bits of the operation word. The block also checks the reported count of address extension words. An illegal opcode makes the block drop the request and raise an emulation-trap request. A legal opcode makes the block open the operation with a read of the coprocessor's save register. No access to the coprocessor comes before that read.

The save register returns a 16-bit format word. The high byte of that word is a format code and the low byte is a count of state bytes. When the code means "not ready", the block pulses an interrupt window for one cycle and then reads the save register again. This repeats for as long as the coprocessor stays not ready. When a valid format word arrives, the block writes that word, packed with a null half-word, to the resolved destination address. It then copies the state as 32-bit words, each read from the coprocessor's operand register, to successive memory addresses. The addresses count downward in predecrement mode and upward in the other legal modes.

Top module: `csave_seq`

## Requirements
- R1: The mode field is opWord[5:0], with mode = bits [5:3] and register = bits [2:0]. A start is accepted only for mode 2, 4, 5 or 6, or for mode 7 with register 0 or 1. Any other field raises `fline` for exactly one cycle, the cycle after start. It then returns to idle with no coprocessor read and no memory write.
- R2: Extension-word counts from 0 to 5 are accepted. On the `done` cycle, `instBytes` equals 2*(extWords+1). A count of 6 or 7 is treated as illegal, as in R1.
- R3: In the cycle after an accepted start, the block issues its first access. That access is a read (`crRdEn`=1) of the save register (`crSel`=0), and no memory write comes before it.
- R4: A save-register reply whose bits [15:8] equal 8'h01 means not ready. The block then asserts `intWin` for one cycle, and in the next cycle it reads the save register again.
- R5: For a valid reply, the first memory write goes to `dstAddr` with data {format word, 16'h0000}.
- R6: After the format write, the block performs ceil(len/4) operand-register reads (`crSel`=1), where len is format bits [7:0]. Each read word is written to memory in the cycle after its read. Write k goes to dstAddr-4k in predecrement mode (mode 4) and to dstAddr+4k in the other modes.
- R7: A length of 0 ends the operation after the format write alone. No operand read takes place.
- R8: `busy` is high from the cycle after start until the `done` cycle, inclusive. `done` pulses once per accepted operation. A start that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a context save |
| opWord | input | 16 | Decoded operation word; bits [5:0] hold the mode field |
| extWords | input | 3 | Number of address extension words the instruction carries |
| dstAddr | input | 32 | Resolved destination address |
| crRdEn | output | 1 | Coprocessor register read strobe |
| crSel | output | 1 | Register select: 0 save, 1 operand |
| crRdData | input | 32 | Read data, valid the cycle after the strobe |
| memWe | output | 1 | Memory word write strobe |
| memAddr | output | 32 | Memory write address |
| memWData | output | 32 | Memory write data |
| intWin | output | 1 | One-cycle interrupt window on each not-ready retry |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fline | output | 1 | One-cycle emulation-trap request for an illegal opcode |
| instBytes | output | 4 | Instruction length in bytes, valid with done |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and data, 8-bit length field, not-ready code 8'h01, and at most five extension words. At this size it can sweep every one of the 64 mode-field values against all eight extension counts, which covers every legal and illegal decode. For three representative legal modes, including predecrement, it also sweeps zero to three not-ready retries against state lengths of 0 to 17 bytes. That second sweep reaches the zero-length case, partial last words and descending addresses. Every run also injects a stray start while the block is busy.

// File: rtl/csave_pkg.sv
package csave_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_FLT, S_POLL, S_PCHK, S_INTW, S_FMTW, S_OPRD, S_OPWR, S_DONE
  } seqState_t;

  typedef struct packed {
    logic capOp;     // latch destination, direction, length at start
    logic capFmt;    // latch format word and word count
    logic stepAddr;  // advance write address by one word
    logic decCount;  // one state word consumed
    logic selFmt;    // write data is the format word
  } dpCtrl_t;

endpackage

// File: rtl/csave_dp.sv
module csave_dp
  import csave_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 8,
  parameter int EXT_W   = 3,
  parameter int MAX_EXT = 5,
  parameter logic [7:0] NR_CODE = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [15:0]       opWord,
  input  logic [EXT_W-1:0]  extWords,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [DATA_W-1:0] crRdData,
  output logic              legal,
  output logic              notReady,
  output logic              cntZero,
  output logic              lastWord,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic [3:0]        instBytes
);
  localparam int CNT_W = LEN_W;
  localparam int STEP  = DATA_W / 8;
  localparam int SH    = $clog2(STEP);

  logic [2:0] eaMode, eaReg;
  logic modeOk, extOk;
  logic [ADDR_W-1:0] addrReg;
  logic descReg;
  logic [15:0] fmtReg;
  logic [CNT_W-1:0] cntReg;
  logic [LEN_W:0] lenRound;

  assign eaMode = opWord[5:3];
  assign eaReg  = opWord[2:0];

  always_comb begin
    case (eaMode)
      3'd2, 3'd4, 3'd5, 3'd6: modeOk = 1'b1;
      3'd7:                    modeOk = (eaReg <= 3'd1);
      default:                 modeOk = 1'b0;
    endcase
  end

  assign extOk    = (32'(extWords) <= MAX_EXT);
  assign legal    = modeOk && extOk;
  assign notReady = (crRdData[15:8] == NR_CODE);
  assign lenRound = {1'b0, crRdData[LEN_W-1:0]} + (LEN_W+1)'(STEP - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      descReg   <= 1'b0;
      fmtReg    <= '0;
      cntReg    <= '0;
      instBytes <= '0;
    end else begin
      if (ctl.capOp) begin
        addrReg   <= dstAddr;
        descReg   <= (eaMode == 3'd4);
        instBytes <= 4'((32'(extWords) + 1) * 2);
      end else if (ctl.stepAddr) begin
        addrReg <= descReg ? addrReg - ADDR_W'(STEP) : addrReg + ADDR_W'(STEP);
      end
      if (ctl.capFmt) begin
        fmtReg <= crRdData[15:0];
        cntReg <= CNT_W'(lenRound >> SH);
      end else if (ctl.decCount) begin
        cntReg <= cntReg - 1'b1;
      end
    end
  end

  assign cntZero  = (cntReg == '0);
  assign lastWord = (cntReg == CNT_W'(1));
  assign memAddr  = addrReg;
  assign memWData = ctl.selFmt ? DATA_W'({fmtReg, 16'h0000}) : crRdData;

endmodule

// File: rtl/csave_ctl.sv
module csave_ctl
  import csave_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    legal,
  input  logic    notReady,
  input  logic    cntZero,
  input  logic    lastWord,
  output dpCtrl_t ctl,
  output logic    crRdEn,
  output logic    crSel,
  output logic    memWe,
  output logic    intWin,
  output logic    busy,
  output logic    done,
  output logic    fline
);
  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    case (state)
      S_IDLE: if (start) begin
        if (legal) begin
          ctl.capOp = 1'b1;
          nextState = S_POLL;
        end else begin
          nextState = S_FLT;
        end
      end
      S_FLT:  nextState = S_IDLE;
      S_POLL: nextState = S_PCHK;
      S_PCHK: if (notReady) nextState = S_INTW;
              else begin
                ctl.capFmt = 1'b1;
                nextState  = S_FMTW;
              end
      S_INTW: nextState = S_POLL;
      S_FMTW: begin
        ctl.selFmt   = 1'b1;
        ctl.stepAddr = 1'b1;
        nextState    = cntZero ? S_DONE : S_OPRD;
      end
      S_OPRD: nextState = S_OPWR;
      S_OPWR: begin
        ctl.stepAddr = 1'b1;
        ctl.decCount = 1'b1;
        nextState    = lastWord ? S_DONE : S_OPRD;
      end
      S_DONE: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign crRdEn = (state == S_POLL) || (state == S_OPRD);
  assign crSel  = (state == S_OPRD);
  assign memWe  = (state == S_FMTW) || (state == S_OPWR);
  assign intWin = (state == S_INTW);
  assign busy   = (state != S_IDLE);
  assign done   = (state == S_DONE);
  assign fline  = (state == S_FLT);

endmodule

// File: rtl/csave_seq.sv
module csave_seq
  import csave_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 8,
  parameter int EXT_W   = 3,
  parameter int MAX_EXT = 5,
  parameter logic [7:0] NR_CODE = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [15:0]       opWord,
  input  logic [EXT_W-1:0]  extWords,
  input  logic [ADDR_W-1:0] dstAddr,
  output logic              crRdEn,
  output logic              crSel,
  input  logic [DATA_W-1:0] crRdData,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic              intWin,
  output logic              busy,
  output logic              done,
  output logic              fline,
  output logic [3:0]        instBytes
);
  dpCtrl_t ctl;
  logic legal, notReady, cntZero, lastWord;

  csave_ctl ctl_i (
    .clk(clk), .rstN(rstN), .start(start), .legal(legal),
    .notReady(notReady), .cntZero(cntZero), .lastWord(lastWord),
    .ctl(ctl), .crRdEn(crRdEn), .crSel(crSel), .memWe(memWe),
    .intWin(intWin), .busy(busy), .done(done), .fline(fline)
  );

  csave_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .EXT_W(EXT_W), .MAX_EXT(MAX_EXT), .NR_CODE(NR_CODE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opWord(opWord),
    .extWords(extWords), .dstAddr(dstAddr), .crRdData(crRdData),
    .legal(legal), .notReady(notReady), .cntZero(cntZero),
    .lastWord(lastWord), .memAddr(memAddr), .memWData(memWData),
    .instBytes(instBytes)
  );

endmodule

// File: rtl/csave_chk.sv
module csave_chk (
  input logic clk,
  input logic rstN,
  input logic crRdEn,
  input logic crSel,
  input logic memWe,
  input logic intWin,
  input logic busy,
  input logic done,
  input logic fline
);
  // R4
  retry_reread_chk: assert property (@(posedge clk) disable iff (!rstN)
    intWin |=> (crRdEn && !crSel));

  // R1
  fault_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    fline |=> (!busy && !fline));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R3
  write_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R6
  write_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R6
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWe, crRdEn, intWin, done, fline}));

endmodule

bind csave_seq csave_chk chk_i (
  .clk(clk), .rstN(rstN), .crRdEn(crRdEn), .crSel(crSel), .memWe(memWe),
  .intWin(intWin), .busy(busy), .done(done), .fline(fline)
);

// File: tb/csave_seq_tb.sv
module csave_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [15:0] opWord = '0;
  logic [2:0] extWords = '0;
  logic [31:0] dstAddr = '0;
  logic crRdEn, crSel, memWe, intWin, busy, done, fline;
  logic [31:0] crRdData = '0;
  logic [31:0] memAddr, memWData;
  logic [3:0] instBytes;

  int checks = 0;
  int errors = 0;

  // coprocessor model state
  int nrLeft = 0;
  int fmtLen = 0;
  int opIdx = 0;

  // monitor state
  int wrIdx = 0;
  int winCnt = 0;
  int doneCnt = 0;
  int flineCnt = 0;
  int rdCnt = 0;
  int opRdCnt = 0;
  logic [3:0] seenBytes = '0;
  logic descExp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csave_seq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opWord(opWord),
    .extWords(extWords), .dstAddr(dstAddr), .crRdEn(crRdEn), .crSel(crSel),
    .crRdData(crRdData), .memWe(memWe), .memAddr(memAddr),
    .memWData(memWData), .intWin(intWin), .busy(busy), .done(done),
    .fline(fline), .instBytes(instBytes)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // coprocessor register responder: data valid the cycle after the strobe
  always @(posedge clk) begin
    if (crRdEn) begin
      if (!crSel) begin
        if (nrLeft > 0) begin
          crRdData <= 32'h0000_0100;
          nrLeft   <= nrLeft - 1;
        end else begin
          crRdData <= {16'h0000, 8'h60, 8'(fmtLen)};
        end
      end else begin
        crRdData <= {16'hC0DE, 16'(opIdx)};
        opIdx    <= opIdx + 1;
      end
    end
  end

  // port monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (crRdEn) begin
        rdCnt++;
        if (crSel) opRdCnt++;
      end
      if (intWin) winCnt++;
      if (fline) flineCnt++;
      if (done) begin
        doneCnt++;
        seenBytes = instBytes;
      end
      if (memWe) begin
        logic [31:0] eAddr, eData;
        eAddr = descExp ? dstAddr - 32'(4 * wrIdx) : dstAddr + 32'(4 * wrIdx);
        eData = (wrIdx == 0) ? {8'h60, 8'(fmtLen), 16'h0000}
                             : {16'hC0DE, 16'(wrIdx - 1)};
        if (wrIdx == 0) begin
          chk(rdCnt >= 1, "R3", "read before first write", rdCnt, 1);
          chk(memAddr == eAddr, "R5", "format address", memAddr, eAddr);
          chk(memWData == eData, "R5", "format data", memWData, eData);
        end else begin
          chk(memAddr == eAddr, "R6", "state address", memAddr, eAddr);
          chk(memWData == eData, "R6", "state data", memWData, eData);
        end
        wrIdx++;
      end
    end
  end

  function automatic bit legalRef(input int f, input int e);
    int m, r;
    m = f / 8;
    r = f % 8;
    return (e <= 5) && (m == 2 || m == 4 || m == 5 || m == 6 || (m == 7 && r <= 1));
  endfunction

  task automatic runOne(input int field, input int ext, input int retries,
                        input int len, input bit stray);
    bit isLegal;
    int words;
    int guard;
    isLegal = legalRef(field, ext);
    words = (len + 3) / 4;
    @(negedge clk);
    nrLeft = retries; fmtLen = len; opIdx = 0;
    wrIdx = 0; winCnt = 0; doneCnt = 0; flineCnt = 0; rdCnt = 0; opRdCnt = 0;
    seenBytes = '0;
    descExp = (field / 8 == 4);
    opWord = {10'b1111_0010_10, 6'(field)};
    extWords = 3'(ext);
    dstAddr = 32'h0004_0000 + 32'(field * 256);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (isLegal) begin
      chk(crRdEn && !crSel && !memWe, "R3", "first access is save read",
          {crRdEn, crSel, memWe}, 3'b100);
      chk(busy, "R8", "busy after start", busy, 1);
      if (stray) begin
        opWord = 16'hF200;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      guard = 0;
      while (doneCnt == 0 && guard < 400) begin
        @(negedge clk);
        guard++;
      end
      chk(doneCnt == 1, "R8", "done pulse", doneCnt, 1);
      @(negedge clk);
      chk(!busy && doneCnt == 1, "R8", "idle after done", {busy, 8'(doneCnt)}, 1);
      chk(flineCnt == 0, "R8", "stray start ignored", flineCnt, 0);
      chk(winCnt == retries, "R4", "interrupt windows", winCnt, retries);
      chk(rdCnt == retries + 1 + words, "R4", "total reads", rdCnt, retries + 1 + words);
      chk(opRdCnt == words, (len == 0) ? "R7" : "R6", "operand reads", opRdCnt, words);
      chk(wrIdx == words + 1, (len == 0) ? "R7" : "R6", "write count", wrIdx, words + 1);
      chk(seenBytes == 4'(2 * (ext + 1)), "R2", "instruction bytes", seenBytes, 2 * (ext + 1));
    end else begin
      chk(fline && !crRdEn && !memWe, "R1", "fault pulse", {fline, crRdEn, memWe}, 3'b100);
      @(negedge clk);
      chk(!fline && !busy, "R1", "fault clears", {fline, busy}, 0);
      repeat (2) @(negedge clk);
      chk(rdCnt == 0 && wrIdx == 0 && flineCnt == 1,
          (ext > 5) ? "R2" : "R1", "no access on illegal", rdCnt + wrIdx, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fline && !memWe && !crRdEn, "R8", "reset state",
        {busy, done, fline, memWe, crRdEn}, 0);
    rstN = 1'b1;
    // full decode sweep
    for (int f = 0; f < 64; f++)
      for (int e = 0; e < 8; e++)
        runOne(f, e, (f + e) % 2, 4, 1'b0);
    // retry and length sweep on representative legal modes
    for (int mi = 0; mi < 3; mi++) begin
      int fld;
      fld = (mi == 0) ? 6'o20 : (mi == 1) ? 6'o43 : 6'o71;
      for (int r = 0; r < 4; r++)
        for (int l = 0; l < 18; l++)
          runOne(fld, (l + r) % 6, r, l, 1'b1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule